// File: doc/BRIEF.md
# Testable Double-Edge Data Capture Cell

This block stores a data word on both transitions of a slow capture clock `e`. Two storage latches sit side by side. The rising-side latch is open while `e` is high, and the falling-side latch is open while `e` is low. A controlled-swap stage acts as a two-way selector. It drives `q` from whichever latch is closed at that moment. A word presented just before an edge of `e` therefore appears on `q` after that edge and stays there until the next edge.

The whole cell runs from a fast system clock `clk`, and it treats `e` as a sampled level. A phase state machine has two states, `PH_LOW` and `PH_HIGH`, with transitions `RISE` (PH_LOW to PH_HIGH when `e` is sampled 1) and `FALL` (PH_HIGH to PH_LOW when `e` is sampled 0). The state stays unchanged otherwise. Each latch has its own two-bit mode code, `{c1,c2}`, which selects one of four states:

- `LM_NORMAL` (01): follow `d` while open, hold while closed.
- `LM_FORCE0` (00): load all zeros, with feedback cut.
- `LM_FORCE1` (11): load all ones, with feedback cut.
- `LM_FREEZE` (10): hold regardless of `e`.

Both stored words come out on tap ports. The tap ports give a copy of each latch content without loading the output path. In the two constant modes, an all-zeros word exposes any stuck-at-1 defect and an all-ones word exposes any stuck-at-0 defect.

Top module: `dual_edge_capture`

## Requirements
- R1: While `rst_n` is low, `q`, `rise_tap` and `fall_tap` are all zero and the phase state is PH_LOW.
- R2: In LM_NORMAL, after the first `clk` edge that samples `e`=1 following a sample of `e`=0, `q` equals `d` as sampled at the previous `clk` edge. `q` then stays unchanged while `e` remains 1, whatever `d` does.
- R3: In LM_NORMAL, after the first `clk` edge that samples `e`=0 following a sample of `e`=1, `q` equals `d` as sampled at the previous `clk` edge. `q` then stays unchanged while `e` remains 0.
- R4: In LM_NORMAL, `rise_tap` takes `d` one `clk` edge after each sample with `e`=1 and holds after samples with `e`=0. `fall_tap` behaves the same way with the levels of `e` swapped.
- R5: Mode code 00 on a latch makes its tap all zeros one `clk` edge later, independent of `d` and `e`.
- R6: Mode code 11 on a latch makes its tap all ones one `clk` edge later, independent of `d` and `e`.
- R7: Mode code 10 on a latch keeps its tap unchanged, independent of `d` and `e`.
- R8: The mode code of one latch has no effect on the other latch's tap.
- R9: `q` equals `fall_tap` when the most recent `e` sample was 1, and `rise_tap` when it was 0. This holds in every mode. The swap stage conserves the number of ones across its two outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| e | input | 1 | Capture clock level, sampled on `clk` |
| d | input | W | Data word |
| rise_c1 | input | 1 | Mode bit 1 of the rising-side latch |
| rise_c2 | input | 1 | Mode bit 2 of the rising-side latch |
| fall_c1 | input | 1 | Mode bit 1 of the falling-side latch |
| fall_c2 | input | 1 | Mode bit 2 of the falling-side latch |
| q | output | W | Captured word |
| rise_tap | output | W | Copy of the rising-side latch content |
| fall_tap | output | W | Copy of the falling-side latch content |

## Verification
The hardest case is the word that changes in the same `clk` cycle as `e`. The cell must show the word from the cycle before, not the new one. The stimulus changes `d` together with every `e` transition and also sends single-cycle pulses on `e`. Mixed per-latch codes, such as one latch forced to zeros and the other to ones while `e` toggles, show that the selector follows the phase state even when neither latch is in normal mode.

// File: rtl/dec_pkg.sv
package dec_pkg;
    typedef enum logic [1:0] {
        LM_FORCE0 = 2'b00,
        LM_NORMAL = 2'b01,
        LM_FREEZE = 2'b10,
        LM_FORCE1 = 2'b11
    } latch_mode_e;

    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } phase_e;

    function automatic latch_mode_e decode_mode(input logic c1, input logic c2);
        return latch_mode_e'({c1, c2});
    endfunction
endpackage

// File: rtl/dec_phase_fsm.sv
module dec_phase_fsm
    import dec_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   e,
    output phase_e phase
);
    phase_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_LOW:  if (e)  state_d = PH_HIGH;  // RISE
            PH_HIGH: if (!e) state_d = PH_LOW;   // FALL
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PH_LOW;
        else        state_q <= state_d;
    end

    assign phase = state_q;

    assert_phase_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        e |=> (state_q == PH_HIGH));
endmodule

// File: rtl/dec_rev_latch.sv
module dec_rev_latch
    import dec_pkg::*;
#(
    parameter int W        = 4,
    parameter bit OPEN_HIGH = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         e,
    input  logic         c1,
    input  logic         c2,
    input  logic [W-1:0] d,
    output logic [W-1:0] hold
);
    localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

    logic         open_en;
    latch_mode_e  mode;
    logic [W-1:0] hold_q, hold_d;

    generate
        if (OPEN_HIGH) begin : g_pos
            assign open_en = e;
        end else begin : g_neg
            assign open_en = ~e;
        end
    endgenerate

    assign mode = decode_mode(c1, c2);

    // Reversible-style update: data gated by enable, feedback gated by its complement
    always_comb begin
        hold_d = hold_q;
        unique case (mode)
            LM_NORMAL: hold_d = ({W{open_en}} & d) | ({W{~open_en}} & hold_q);
            LM_FORCE0: hold_d = '0;
            LM_FORCE1: hold_d = ALL_ONES;
            LM_FREEZE: hold_d = hold_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hold_q <= '0;
        else        hold_q <= hold_d;
    end

    assign hold = hold_q;

    assert_force_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == LM_FORCE0) |=> (hold == '0));
    assert_force_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == LM_FORCE1) |=> (hold == ALL_ONES));
    assert_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == LM_FREEZE) |=> $stable(hold));
    assert_closed_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == LM_NORMAL && !open_en) |=> $stable(hold));
endmodule

// File: rtl/dec_cswap.sv
module dec_cswap #(
    parameter int W = 4
) (
    input  logic         sel,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] x,
    output logic [W-1:0] y
);
    always_comb begin
        x = a;
        y = b;
        if (sel) begin
            x = b;
            y = a;
        end
    end

    always_comb begin
        assert_conserve_R9: assert ($countones({x, y}) == $countones({a, b}));
    end
endmodule

// File: rtl/dual_edge_capture.sv
module dual_edge_capture
    import dec_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         e,
    input  logic [W-1:0] d,
    input  logic         rise_c1,
    input  logic         rise_c2,
    input  logic         fall_c1,
    input  logic         fall_c2,
    output logic [W-1:0] q,
    output logic [W-1:0] rise_tap,
    output logic [W-1:0] fall_tap
);
    phase_e       phase;
    logic [W-1:0] idle_word;

    dec_phase_fsm u_phase (
        .clk(clk), .rst_n(rst_n), .e(e), .phase(phase)
    );

    dec_rev_latch #(.W(W), .OPEN_HIGH(1'b1)) u_rise (
        .clk(clk), .rst_n(rst_n), .e(e), .c1(rise_c1), .c2(rise_c2),
        .d(d), .hold(rise_tap)
    );

    dec_rev_latch #(.W(W), .OPEN_HIGH(1'b0)) u_fall (
        .clk(clk), .rst_n(rst_n), .e(e), .c1(fall_c1), .c2(fall_c2),
        .d(d), .hold(fall_tap)
    );

    // Select the latch that is currently storing
    dec_cswap #(.W(W)) u_swap (
        .sel(phase == PH_HIGH), .a(rise_tap), .b(fall_tap), .x(q), .y(idle_word)
    );

    assert_high_steady_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_HIGH && e && decode_mode(fall_c1, fall_c2) == LM_NORMAL) |=> $stable(q));
    assert_low_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_LOW && !e && decode_mode(rise_c1, rise_c2) == LM_NORMAL) |=> $stable(q));
    assert_idle_word_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_HIGH) |-> (idle_word == rise_tap));
endmodule

// File: tb/dual_edge_capture_tb.sv
module dual_edge_capture_tb;
    localparam int W = 4;

    typedef struct {
        logic [W-1:0] q;
        logic [W-1:0] rt;
        logic [W-1:0] ft;
        string        tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         e = 1'b0;
    logic [W-1:0] d = '0;
    logic         rise_c1 = 1'b0, rise_c2 = 1'b1, fall_c1 = 1'b0, fall_c2 = 1'b1;
    logic [W-1:0] q, rise_tap, fall_tap;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    exp_t sb[$];

    logic [W-1:0] m_r = '0, m_f = '0;
    logic         m_ph = 1'b0;

    always #5 clk = ~clk;

    dual_edge_capture #(.W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .e(e), .d(d),
        .rise_c1(rise_c1), .rise_c2(rise_c2), .fall_c1(fall_c1), .fall_c2(fall_c2),
        .q(q), .rise_tap(rise_tap), .fall_tap(fall_tap)
    );

    function automatic logic [W-1:0] lat(input logic [W-1:0] cur, input logic [1:0] m,
                                         input logic open, input logic [W-1:0] dv);
        case (m)
            2'b00: return '0;
            2'b11: return '1;
            2'b10: return cur;
            default: return open ? dv : cur;
        endcase
    endfunction

    task automatic cmp(input string tag, input string what, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic step(input logic [W-1:0] dv, input logic ev, input logic [1:0] rm,
                        input logic [1:0] fm, input string tag);
        exp_t it;
        d = dv; e = ev;
        {rise_c1, rise_c2} = rm;
        {fall_c1, fall_c2} = fm;
        @(posedge clk); #1;
        m_r  = lat(m_r, rm, ev, dv);
        m_f  = lat(m_f, fm, !ev, dv);
        m_ph = ev;
        it.q = m_ph ? m_f : m_r;
        it.rt = m_r; it.ft = m_f; it.tag = tag;
        sb.push_back(it);
    endtask

    initial begin : monitor
        forever begin
            @(negedge clk);
            while (sb.size() > 0) begin
                exp_t it;
                it = sb.pop_front();
                cmp(it.tag, "q", q, it.q);
                cmp(it.tag, "rise_tap", rise_tap, it.rt);
                cmp(it.tag, "fall_tap", fall_tap, it.ft);
            end
        end
    end

    initial begin : watchdog
        #1_000_000;
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin : driver
        d = 4'hA; e = 1'b1;
        #23;
        cmp("R1", "q", q, '0);
        cmp("R1", "rise_tap", rise_tap, '0);
        cmp("R1", "fall_tap", fall_tap, '0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        e = 1'b0; d = '0;

        // R2 R3 R4: normal mode, d changes together with every e transition
        for (int i = 0; i < 36; i++) begin
            logic ev;
            ev = ((i / 3) % 2) == 1;
            step(W'((i * 7 + 3) & 15), ev, 2'b01, 2'b01, ev ? "R2 R4" : "R3 R4");
        end
        // single-cycle pulses on e
        for (int i = 0; i < 12; i++) begin
            step(W'((i * 5 + 9) & 15), (i % 4) == 1, 2'b01, 2'b01, "R2 R3");
        end
        // R5 R8: rising-side forced to zeros, falling-side normal
        for (int i = 0; i < 8; i++) step(W'(i + 6), i[1], 2'b00, 2'b01, "R5 R8");
        // R6 R8: rising-side forced to ones, falling-side normal
        for (int i = 0; i < 8; i++) step(W'(i * 3), i[0], 2'b11, 2'b01, "R6 R8");
        // R5 R6: both sides forced, all-zeros then all-ones vectors
        for (int i = 0; i < 4; i++) step('0, i[0], 2'b00, 2'b00, "R5");
        for (int i = 0; i < 4; i++) step('1, i[0], 2'b11, 2'b11, "R6");
        // R7: load known words, then freeze each side in turn
        for (int i = 0; i < 4; i++) step(W'(4'h5 + i), i[0], 2'b01, 2'b01, "R4");
        for (int i = 0; i < 6; i++) step(W'(i * 11), i[0], 2'b10, 2'b01, "R7 R8");
        for (int i = 0; i < 6; i++) step(W'(i * 13), i[1], 2'b01, 2'b10, "R7 R8");
        // R9: opposite constants on each side, selector follows e
        for (int i = 0; i < 10; i++) step(W'(i), (i % 3) == 0, 2'b00, 2'b11, "R9");
        for (int i = 0; i < 6; i++) step(W'(i), i[0], 2'b11, 2'b00, "R9");
        // back to normal
        for (int i = 0; i < 10; i++) step(W'(i * 9 + 1), i[1], 2'b01, 2'b01, "R2 R3");

        @(negedge clk); @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule